// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

A single-port synchronous static RAM with late-write timing. Select, write enable, byte enables and address are registered on a rising clock edge. For a write, the data word is sampled on the following rising edge. A read returns registered data one cycle after its address is registered.

Write data arrives one cycle after its address, so a completed write may still be waiting for the array port when a later read uses that port. It waits in a one-entry pending buffer. The buffer is committed on the first edge on which no read claims the array. Reads are compared against both the write whose data is arriving and the pending entry. Matching byte lanes are bypassed, so reads always see the latest written value.

The width is chosen at build time. It is either two or four 9-bit lanes, and the depth halves when the width doubles, so capacity stays the same. A sleep input blocks new operations but lets an outstanding write finish.

Top module: `lw_sram`

## Requirements
- R1: An edge with cs_i=1, we_i=0, sleep_i=0 accepts a read. rvalid_o=1 and the word appear on rdata_o after the next edge, and only then.
- R2: An edge with cs_i=1, we_i=1, sleep_i=0 accepts a write of addr_i under mask be_i. The word for it is taken from wdata_i on the next edge.
- R3: be_i[k] gates lane k, which is bits [9k+8:9k]. A write changes only its enabled lanes.
- R4: A read accepted on the same edge that samples a write's data, at the same address, returns the new lanes merged with the old ones.
- R5: A read that hits the pending buffered write returns the buffered lanes where that write's mask is set, and the array lanes elsewhere.
- R6: Writes may be accepted on every consecutive edge. None of them is lost, and the pending buffer never has to hold two entries.
- R7: When rvalid_o=0, rdata_o is all zero. That is the case after deselect, write and sleep edges.
- R8: While sleep_i=1, cs_i, we_i, be_i and addr_i are ignored. A write or read requested then has no effect.
- R9: A write accepted before sleep finishes its data phase even on a sleep edge. A pending write is committed on the first sleep edge.
- R10: During reset, rvalid_o=0 and rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Select, high to start an operation |
| we_i | input | 1 | High for write, low for read |
| be_i | input | NL | Per-lane write enables |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write word, one cycle after its address |
| sleep_i | input | 1 | Sleep, blocks new operations |
| rdata_o | output | DW | Read word, zero when not valid |
| rvalid_o | output | 1 | Read word valid |

## Verification
The bench reads an address on the edge right after writing it. A design without bypass of the arriving word would return the stale array contents. It then forces a write into the pending buffer with an intervening read and reads it back with a partial mask. A wrong merge would mix up buffered and array lanes. Runs of back-to-back writes, writes issued during sleep, and a write whose data phase falls on a sleep edge target lost or spurious commits, which show up as wrong read-back words. Output timing is scored cycle by cycle, so an extra or missing pipeline stage, or non-zero idle data, is reported.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int unsigned LANE_W = 9;

  function automatic int unsigned lanes_for(input bit wide);
    return wide ? 4 : 2;
  endfunction

  function automatic int unsigned depth_for(input int unsigned base, input bit wide);
    return wide ? base / 2 : base;
  endfunction
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl #(
  parameter int unsigned NL = 2,
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [NL-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  input  logic          sleep_i,
  output logic          rd_go_o,
  output logic          s1_vld_o,
  output logic [AW-1:0] s1_addr_o,
  output logic [NL-1:0] s1_be_o
);
  logic wr_go;

  assign rd_go_o = cs_i & ~we_i & ~sleep_i;
  assign wr_go   = cs_i &  we_i & ~sleep_i;

  // address phase of a write; data follows next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_o  <= 1'b0;
      s1_addr_o <= '0;
      s1_be_o   <= '0;
    end else begin
      s1_vld_o <= wr_go;
      if (wr_go) begin
        s1_addr_o <= addr_i;
        s1_be_o   <= be_i;
      end
    end
  end
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int unsigned NL = 2,
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_go_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          s1_vld_i,
  input  logic [AW-1:0] s1_addr_i,
  input  logic [NL-1:0] s1_be_i,
  input  logic [DW-1:0] wdata_i,
  output logic          buf_vld_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [NL-1:0] arr_be_o,
  output logic [DW-1:0] arr_data_o,
  output logic [NL-1:0] hit_be_o,
  output logic [DW-1:0] hit_data_o
);
  logic [AW-1:0] buf_addr;
  logic [NL-1:0] buf_be;
  logic [DW-1:0] buf_data;
  logic port_free, take_buf, take_new, park;

  assign port_free = ~rd_go_i;
  assign take_buf  = buf_vld_o & port_free;
  assign take_new  = s1_vld_i & port_free & ~take_buf;
  assign park      = s1_vld_i & ~take_new;

  always_comb begin
    arr_we_o   = take_buf | take_new;
    arr_addr_o = take_buf ? buf_addr : s1_addr_i;
    arr_be_o   = take_buf ? buf_be   : s1_be_i;
    arr_data_o = take_buf ? buf_data : wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_vld_o <= 1'b0;
      buf_addr  <= '0;
      buf_be    <= '0;
      buf_data  <= '0;
    end else if (park) begin
      buf_vld_o <= 1'b1;
      buf_addr  <= s1_addr_i;
      buf_be    <= s1_be_i;
      buf_data  <= wdata_i;
    end else if (take_buf) begin
      buf_vld_o <= 1'b0;
    end
  end

  // newest write wins: the arriving word, then the parked one
  always_comb begin
    hit_be_o   = '0;
    hit_data_o = '0;
    if (s1_vld_i && s1_addr_i == rd_addr_i) begin
      hit_be_o   = s1_be_i;
      hit_data_o = wdata_i;
    end else if (buf_vld_o && buf_addr == rd_addr_i) begin
      hit_be_o   = buf_be;
      hit_data_o = buf_data;
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int unsigned NL    = 2,
  parameter int unsigned LW    = 9,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [NL-1:0]    wbe_i,
  input  logic [NL*LW-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [NL*LW-1:0] rdata_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] lane_q;

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[l]) mem[waddr_i] <= wdata_i[l*LW +: LW];
      if (re_i) lane_q <= mem[raddr_i];
    end

    assign rdata_o[l*LW +: LW] = lane_q;
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter bit          WIDE_ORG   = 1'b0,
  parameter int unsigned BASE_WORDS = 1024,
  localparam int unsigned NL    = lanes_for(WIDE_ORG),
  localparam int unsigned DW    = NL * LANE_W,
  localparam int unsigned DEPTH = depth_for(BASE_WORDS, WIDE_ORG),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [NL-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sleep_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic          rd_go, s1_vld, buf_vld;
  logic [AW-1:0] s1_addr, arr_addr;
  logic [NL-1:0] s1_be, arr_be, hit_be, hit_be_q;
  logic [DW-1:0] arr_data, arr_rd, hit_data, hit_data_q, merged;
  logic          arr_we, rd_q;

  lw_sram_ctrl #(.NL(NL), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .cs_i, .we_i, .be_i, .addr_i, .sleep_i,
    .rd_go_o(rd_go), .s1_vld_o(s1_vld), .s1_addr_o(s1_addr), .s1_be_o(s1_be)
  );

  lw_sram_wbuf #(.NL(NL), .AW(AW), .DW(DW)) u_wbuf (
    .clk_i, .rst_ni,
    .rd_go_i(rd_go), .rd_addr_i(addr_i),
    .s1_vld_i(s1_vld), .s1_addr_i(s1_addr), .s1_be_i(s1_be), .wdata_i,
    .buf_vld_o(buf_vld),
    .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_be_o(arr_be), .arr_data_o(arr_data),
    .hit_be_o(hit_be), .hit_data_o(hit_data)
  );

  lw_sram_array #(.NL(NL), .LW(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_array (
    .clk_i,
    .we_i(arr_we), .waddr_i(arr_addr), .wbe_i(arr_be), .wdata_i(arr_data),
    .re_i(rd_go), .raddr_i(addr_i), .rdata_o(arr_rd)
  );

  // bypass lanes captured alongside the array read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= 1'b0;
      hit_be_q   <= '0;
      hit_data_q <= '0;
    end else begin
      rd_q <= rd_go;
      if (rd_go) begin
        hit_be_q   <= hit_be;
        hit_data_q <= hit_data;
      end
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = hit_be_q[l] ? hit_data_q[l*LANE_W +: LANE_W]
                                                    : arr_rd[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_q;
      rdata_o  <= rd_q ? merged : '0;
    end
  end
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int unsigned DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          we_i,
  input logic          sleep_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic          rd_go,
  input logic          s1_vld,
  input logic          buf_vld
);
  assert_read_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && !sleep_i) |=> ##1 rvalid_o);

  assert_write_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && !sleep_i) |=> s1_vld);

  assert_single_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s1_vld && buf_vld));

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);

  assert_nonread_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i && !sleep_i) |=> ##1 !rvalid_o);

  assert_sleep_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !rd_go);

  assert_sleep_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && buf_vld) |=> !buf_vld);
endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .sleep_i(sleep_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o),
  .rd_go(rd_go), .s1_vld(s1_vld), .buf_vld(buf_vld)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
  import lw_sram_pkg::*;
  localparam bit          WIDE  = 1'b0;
  localparam int unsigned NL    = lanes_for(WIDE);
  localparam int unsigned DW    = NL * LANE_W;
  localparam int unsigned DEPTH = depth_for(1024, WIDE);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam logic [DW-1:0] FILL = DW'(18'h2D2D2);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_i = 1'b0, we_i = 1'b0, sleep_i = 1'b0;
  logic [NL-1:0] be_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic rvalid_o;

  always #5 clk = ~clk;

  lw_sram #(.WIDE_ORG(WIDE)) uut (
    .clk_i(clk), .rst_ni, .cs_i, .we_i, .be_i, .addr_i, .wdata_i, .sleep_i,
    .rdata_o, .rvalid_o
  );

  typedef struct {
    logic [DW-1:0] d;
    int            due;
    string         tag;
  } exp_t;

  exp_t          q[$];
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] nxt_wdata = FILL;
  int cyc = 0, checks = 0, errors = 0;
  bit mon_on = 1'b0, done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver: one operation per cycle, write word trails by one cycle
  task automatic op(input bit cs, input bit we, input bit slp, input logic [NL-1:0] be,
                    input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    cs_i = cs; we_i = we; sleep_i = slp; be_i = be; addr_i = a;
    wdata_i = nxt_wdata;
    nxt_wdata = FILL;
    if (cs && !slp && we) begin
      for (int l = 0; l < NL; l++)
        if (be[l]) model[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      nxt_wdata = d;
    end else if (cs && !slp) begin
      e.d = model[a]; e.due = cyc + 2; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 1'b0, '0, '0, '0, "R7");
  endtask

  // monitor: pops expectations as read words emerge
  always @(negedge clk) begin
    if (mon_on && rst_ni) begin
      if (rvalid_o) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected rvalid: actual %h expected none", rdata_o);
        end else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (e.due != cyc || rdata_o !== e.d) begin
            errors++;
            $display("FAIL %s: actual %h@%0d expected %h@%0d", e.tag, rdata_o, cyc, e.d, e.due);
          end
        end
      end else begin
        if (q.size() != 0 && q[0].due == cyc) begin
          exp_t e;
          e = q.pop_front();
          checks++; errors++;
          $display("FAIL %s missing word: actual none expected %h", e.tag, e.d);
        end
        if (rdata_o !== '0) begin
          checks++; errors++;
          $display("FAIL R7 idle data: actual %h expected 0", rdata_o);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rvalid_o !== 1'b0 || rdata_o !== '0) begin
      errors++;
      $display("FAIL R10 reset outputs: actual %b/%h expected 0/0", rvalid_o, rdata_o);
    end
    rst_ni = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R1/R2 plain write then read
    op(1, 1, 0, 2'b11, 10'h010, 18'h12345, "R2");
    idle(1);
    op(1, 0, 0, '0, 10'h010, '0, "R1");
    idle(2);

    // R3 lane masking
    op(1, 1, 0, 2'b11, 10'h020, 18'h3FFFF, "R3");
    op(1, 1, 0, 2'b01, 10'h020, 18'h00000, "R3");
    idle(1);
    op(1, 0, 0, '0, 10'h020, '0, "R3 low lane");
    op(1, 1, 0, 2'b10, 10'h020, 18'h15555, "R3");
    idle(1);
    op(1, 0, 0, '0, 10'h020, '0, "R3 high lane");
    idle(2);

    // R4 read on the data edge of the write
    op(1, 1, 0, 2'b11, 10'h030, 18'h0ABCD, "R4");
    op(1, 0, 0, '0, 10'h030, '0, "R4 full");
    op(1, 1, 0, 2'b01, 10'h030, 18'h3FE77, "R4");
    op(1, 0, 0, '0, 10'h030, '0, "R4 partial");
    idle(2);

    // R5 hit in the pending buffer
    op(1, 1, 0, 2'b11, 10'h040, 18'h11111, "R5");
    op(1, 1, 0, 2'b11, 10'h041, 18'h22222, "R5");
    idle(2);
    op(1, 1, 0, 2'b10, 10'h040, 18'h3FFFF, "R5");
    op(1, 0, 0, '0, 10'h041, '0, "R5 park");
    op(1, 0, 0, '0, 10'h040, '0, "R5 merged");
    op(1, 0, 0, '0, 10'h040, '0, "R5 repeat");
    idle(2);
    op(1, 0, 0, '0, 10'h040, '0, "R5 committed");
    idle(2);

    // R6 back-to-back writes, then interleaved write/read
    for (int i = 0; i < 8; i++)
      op(1, 1, 0, 2'b11, AW'(10'h100 + i), DW'(18'h01000 * (i + 1) + i), "R6");
    for (int i = 0; i < 8; i++)
      op(1, 0, 0, '0, AW'(10'h100 + i), '0, "R6 readback");
    for (int i = 0; i < 4; i++) begin
      op(1, 1, 0, 2'b11, AW'(10'h108 + i), DW'(18'h3C000 + i), "R6");
      op(1, 0, 0, '0, AW'(10'h100 + i), '0, "R6 interleave");
    end
    for (int i = 0; i < 4; i++)
      op(1, 0, 0, '0, AW'(10'h108 + i), '0, "R6 interleave readback");
    idle(2);

    // R8 requests under sleep are ignored
    op(1, 1, 1, 2'b11, 10'h010, 18'h00000, "R8");
    op(1, 0, 1, '0, 10'h010, '0, "R8");
    op(1, 1, 1, 2'b11, 10'h020, 18'h00001, "R8");
    op(0, 0, 0, '0, '0, '0, "R8");
    op(1, 0, 0, '0, 10'h010, '0, "R8 unchanged");
    op(1, 0, 0, '0, 10'h020, '0, "R8 unchanged");
    idle(2);

    // R9 pending write survives sleep; data phase on a sleep edge
    op(1, 1, 0, 2'b11, 10'h051, 18'h05151, "R9");
    op(1, 1, 0, 2'b11, 10'h050, 18'h0F0F0, "R9");
    op(1, 0, 0, '0, 10'h051, '0, "R9 park");
    op(0, 0, 1, '0, '0, '0, "R9");
    op(0, 0, 1, '0, '0, '0, "R9");
    op(0, 0, 0, '0, '0, '0, "R9");
    op(1, 0, 0, '0, 10'h050, '0, "R9 after sleep");
    op(1, 1, 0, 2'b11, 10'h060, 18'h36363, "R9");
    op(1, 0, 1, '0, 10'h060, '0, "R9");
    op(0, 0, 0, '0, '0, '0, "R9");
    op(1, 0, 0, '0, 10'h060, '0, "R9 data on sleep edge");
    idle(4);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 leftover words: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule